// File: doc/BRIEF.md
# Ordered Cipher Key Loader with CRC-8 Validity Token

This block holds one 128-bit cipher context key that software loads as four 32-bit words through a configuration port. While the words arrive it follows their order and folds each accepted word into an 8-bit CRC. The key counts as loaded only when the words come in strictly ascending order, starting with word 0 and ending with word 3, each written exactly once. The CRC then becomes visible and acts as the validity token: a nonzero value tells the cipher datapath that the key may be used, and a zero value sends that datapath to bypass.

Three one-way locks guard the block, and each clears only on reset. The key lock freezes the key words. The context lock also freezes the key words and additionally closes the gate for writes to the context's other configuration and nonce registers, which live outside this block. The global lock freezes everything, including the other lock bits, so the CRC keeps its value until reset. A lock requested in the same cycle as a write already blocks that write.

Top module: `ctx_key_loader`

## Requirements
- R1: `key_usable` rises only in the cycle after an accepted write to word index 3 that ends an unbroken run of accepted writes to word indices 0, 1, 2 and 3, in that order.
- R2: The CRC uses the polynomial x^8 + x^2 + x + 1 (0x07), an initial value of 0x00 and no final XOR. It consumes word 0 first, each word most significant bit first, one word per write cycle. After a completed run, `crc_value` equals this CRC of the four words.
- R3: `crc_value` is 0x00 after reset. Every accepted key-word write other than the one completing a run sets it to 0x00 in the following cycle.
- R4: An accepted write to word 0 starts a new run at any time. An accepted write whose index differs from the next expected one ends the current run, and `crc_value` stays 0x00 until a new run starting with word 0 completes.
- R5: `key_usable` is 1 exactly when `crc_value` is nonzero, so a key whose CRC is 0x00 (for example all zero bits) is never usable.
- R6: A pulse on `key_lock_set` sets `key_locked`, which stays 1 until reset. While it is 1, key-word writes change neither `key_out` nor `crc_value`.
- R7: A pulse on `ctx_lock_set` sets both `ctx_locked` and `key_locked`, which stay 1 until reset. While `ctx_locked` is 1, `cfg_wr_ok` is 0 even when `cfg_wr` is 1.
- R8: A pulse on `glob_lock_set` sets `glob_locked` until reset. From then on, key-word writes, lock requests and configuration writes are ignored, and `crc_value` keeps its value.
- R9: A lock request in the same cycle as a key-word write or configuration write blocks that write.
- R10: `key_out` holds word i at bits [32*i+31 : 32*i]. Each word is 0 after reset and takes the data of the latest accepted write to its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kw_wr | input | 1 | Key-word write strobe |
| kw_idx | input | 2 | Index of the key word being written |
| kw_data | input | 32 | Key-word data |
| key_lock_set | input | 1 | Request to set the key lock |
| ctx_lock_set | input | 1 | Request to set the context lock |
| glob_lock_set | input | 1 | Request to set the global lock |
| cfg_wr | input | 1 | Write strobe for the context's configuration and nonce registers |
| cfg_wr_ok | output | 1 | Gated configuration write strobe |
| key_out | output | 128 | Stored key for the cipher |
| crc_value | output | 8 | CRC validity token, 0 when the key is not valid |
| key_usable | output | 1 | Key may be used by the cipher |
| key_locked | output | 1 | Key lock state |
| ctx_locked | output | 1 | Context lock state |
| glob_locked | output | 1 | Global lock state |

## Verification
Two things can coincide in a single cycle: a key-word write or configuration write, and a lock request that would block it. The bench raises `kw_wr` together with `key_lock_set`, `ctx_lock_set` or `glob_lock_set` on the same clock edge. It then checks that the stored word and the CRC are unchanged, that the lock flag is set, and that `cfg_wr_ok` stayed low in that cycle. A second overlap is a word-0 restart in the middle of a run. The bench compares the resulting CRC with a polynomial long division of only the most recent words.

// File: rtl/ckl_pkg.sv
package ckl_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned CRC_W    = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  // Fold one word into the running CRC, most significant bit first.
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] crc_in,
                                                input logic [WORD_W-1:0] word);
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc_in;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      fb = c[CRC_W-1] ^ word[b];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/ckl_lock_ctrl.sv
module ckl_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic key_lock_set,
  input  logic ctx_lock_set,
  input  logic glob_lock_set,
  input  logic kw_wr,
  input  logic cfg_wr,
  output logic key_locked,
  output logic ctx_locked,
  output logic glob_locked,
  output logic kw_accept,
  output logic cfg_accept
);
  logic wr_open;
  logic key_lock_d, ctx_lock_d, glob_lock_d;

  // Writes are possible only with no global lock, present or requested.
  assign wr_open     = !glob_locked && !glob_lock_set;
  assign ctx_lock_d  = ctx_locked | (wr_open & ctx_lock_set);
  assign key_lock_d  = key_locked | (wr_open & (key_lock_set | ctx_lock_set));
  assign glob_lock_d = glob_locked | glob_lock_set;

  assign kw_accept  = kw_wr  && wr_open && !key_lock_d;
  assign cfg_accept = cfg_wr && wr_open && !ctx_lock_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_locked  <= 1'b0;
      ctx_locked  <= 1'b0;
      glob_locked <= 1'b0;
    end else begin
      key_locked  <= key_lock_d;
      ctx_locked  <= ctx_lock_d;
      glob_locked <= glob_lock_d;
    end
  end

  assert_key_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_locked |=> key_locked);
  assert_ctx_forces_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_locked |-> key_locked);
  assert_glob_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    glob_locked |=> (glob_locked && $stable(key_locked) && $stable(ctx_locked)));
  assert_cfg_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_accept |-> (!ctx_locked && !glob_locked));
endmodule

// File: rtl/ckl_key_store.sv
module ckl_key_store #(
  parameter int unsigned NWORDS = 4,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned IDX_W = $clog2(NWORDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [WORD_W-1:0]        wr_data,
  output logic [NWORDS*WORD_W-1:0] key
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g))) word_q <= wr_data;
    end
    assign key[g*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/ckl_seq_crc.sv
module ckl_seq_crc
  import ckl_pkg::*;
#(
  parameter int unsigned NWORDS = 4,
  localparam int unsigned IDX_W = $clog2(NWORDS),
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [CRC_W-1:0]  crc_value,
  output logic              run_done
);
  logic             run_active;
  logic [IDX_W-1:0] next_idx;
  logic [CRC_W-1:0] run_crc;
  logic             is_start, is_next;
  logic [CRC_W-1:0] fold_start, fold_next;

  assign is_start   = wr_en && (wr_idx == '0);
  assign is_next    = wr_en && !is_start && run_active && (wr_idx == next_idx);
  assign run_done   = is_next && (wr_idx == LAST_IDX);
  assign fold_start = crc_fold('0, wr_data);
  assign fold_next  = crc_fold(run_crc, wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_active <= 1'b0;
      next_idx   <= '0;
      run_crc    <= '0;
      crc_value  <= '0;
    end else if (wr_en) begin
      if (is_start) begin
        run_active <= 1'b1;
        next_idx   <= IDX_W'(1);
        run_crc    <= fold_start;
        crc_value  <= '0;
      end else if (is_next) begin
        run_crc    <= fold_next;
        next_idx   <= next_idx + 1'b1;
        run_active <= !run_done;
        crc_value  <= run_done ? fold_next : '0;
      end else begin
        run_active <= 1'b0;
        crc_value  <= '0;
      end
    end
  end

  assert_crc_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(crc_value));
  assert_crc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !run_done) |=> (crc_value == '0));
  assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_start && !is_next) |=> !run_active);
endmodule

// File: rtl/ctx_key_loader.sv
module ctx_key_loader
  import ckl_pkg::*;
#(
  parameter int unsigned NWORDS = 4,
  localparam int unsigned IDX_W = $clog2(NWORDS),
  localparam int unsigned KEY_W = NWORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kw_wr,
  input  logic [IDX_W-1:0]  kw_idx,
  input  logic [WORD_W-1:0] kw_data,
  input  logic              key_lock_set,
  input  logic              ctx_lock_set,
  input  logic              glob_lock_set,
  input  logic              cfg_wr,
  output logic              cfg_wr_ok,
  output logic [KEY_W-1:0]  key_out,
  output logic [CRC_W-1:0]  crc_value,
  output logic              key_usable,
  output logic              key_locked,
  output logic              ctx_locked,
  output logic              glob_locked
);
  logic kw_accept;
  logic run_done;

  ckl_lock_ctrl u_lock (
    .clk          (clk),
    .rst_n        (rst_n),
    .key_lock_set (key_lock_set),
    .ctx_lock_set (ctx_lock_set),
    .glob_lock_set(glob_lock_set),
    .kw_wr        (kw_wr),
    .cfg_wr       (cfg_wr),
    .key_locked   (key_locked),
    .ctx_locked   (ctx_locked),
    .glob_locked  (glob_locked),
    .kw_accept    (kw_accept),
    .cfg_accept   (cfg_wr_ok)
  );

  ckl_key_store #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (kw_accept),
    .wr_idx (kw_idx),
    .wr_data(kw_data),
    .key    (key_out)
  );

  ckl_seq_crc #(.NWORDS(NWORDS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (kw_accept),
    .wr_idx   (kw_idx),
    .wr_data  (kw_data),
    .crc_value(crc_value),
    .run_done (run_done)
  );

  assign key_usable = |crc_value;

  assert_usable_after_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_usable) |-> $past(run_done));
  assert_locked_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (key_locked || glob_locked) |-> !kw_accept);
  assert_locked_key_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_locked || key_locked) |=> ($stable(key_out) && $stable(crc_value)));
  assert_same_cycle_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (key_lock_set || ctx_lock_set || glob_lock_set) |-> !kw_accept);
endmodule

// File: tb/ctx_key_loader_tb_top.sv
module ctx_key_loader_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         kw_wr = 1'b0;
  logic [1:0]   kw_idx = '0;
  logic [31:0]  kw_data = '0;
  logic         key_lock_set = 1'b0, ctx_lock_set = 1'b0, glob_lock_set = 1'b0;
  logic         cfg_wr = 1'b0;
  logic         cfg_wr_ok;
  logic [127:0] key_out;
  logic [7:0]   crc_value;
  logic         key_usable, key_locked, ctx_locked, glob_locked;

  int checks = 0;
  int errors = 0;
  logic [31:0] mk [4];

  always #2 clk = ~clk;

  ctx_key_loader dut_i (
    .clk(clk), .rst_n(rst_n), .kw_wr(kw_wr), .kw_idx(kw_idx), .kw_data(kw_data),
    .key_lock_set(key_lock_set), .ctx_lock_set(ctx_lock_set),
    .glob_lock_set(glob_lock_set), .cfg_wr(cfg_wr), .cfg_wr_ok(cfg_wr_ok),
    .key_out(key_out), .crc_value(crc_value), .key_usable(key_usable),
    .key_locked(key_locked), .ctx_locked(ctx_locked), .glob_locked(glob_locked)
  );

  // Reference CRC: remainder of (message * x^8) divided by 0x107.
  function automatic logic [7:0] ref_crc(input logic [31:0] w0, w1, w2, w3);
    logic [135:0] m;
    m = {w0, w1, w2, w3, 8'h00};
    for (int p = 135; p >= 8; p--)
      if (m[p]) m[p -: 9] = m[p -: 9] ^ 9'h107;
    return m[7:0];
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) mk[i] = '0;
  endtask

  // Drive one key write; returns after the result is registered.
  task automatic wr(input logic [1:0] idx, input logic [31:0] d, input logic track);
    kw_wr = 1'b1; kw_idx = idx; kw_data = d;
    @(negedge clk);
    kw_wr = 1'b0;
    if (track) mk[idx] = d;
  endtask

  task automatic load_all(input logic [31:0] a, b, c, d);
    wr(2'd0, a, 1'b1); wr(2'd1, b, 1'b1); wr(2'd2, c, 1'b1); wr(2'd3, d, 1'b1);
  endtask

  function automatic logic [127:0] exp_key();
    return {mk[3], mk[2], mk[1], mk[0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] c;
    do_reset();
    // Reset state (R3, R10, R6, R7, R8)
    chk("R3 reset crc", 128'(crc_value), 128'h0);
    chk("R10 reset key", key_out, 128'h0);
    chk("R6 R7 R8 reset locks", 128'({key_locked, ctx_locked, glob_locked, key_usable}), 128'h0);

    // Ordered loads with several patterns (R1, R2, R5, R10)
    for (int n = 0; n < 6; n++) begin
      logic [31:0] a, b, d3, e;
      a = 32'h1357_9BDF * (n + 1); b = ~a ^ (32'h0F0F_0000 << n);
      d3 = 32'h8000_0001 >> n; e = a + b + 32'(n);
      load_all(a, b, d3, e);
      c = ref_crc(a, b, d3, e);
      chk("R2 crc value", 128'(crc_value), 128'(c));
      chk("R5 usable", 128'(key_usable), 128'(c != 0));
      chk("R10 key words", key_out, exp_key());
    end

    // Partial run reads zero before completion (R3)
    wr(2'd0, 32'hA5A5_0001, 1'b1);
    chk("R3 clear on write", 128'(crc_value), 128'h0);
    wr(2'd1, 32'hA5A5_0002, 1'b1); wr(2'd2, 32'hA5A5_0003, 1'b1);
    chk("R1 not yet usable", 128'(key_usable), 128'h0);
    wr(2'd3, 32'hA5A5_0004, 1'b1);
    chk("R1 usable after run", 128'(crc_value), 128'(ref_crc(32'hA5A5_0001, 32'hA5A5_0002, 32'hA5A5_0003, 32'hA5A5_0004)));

    // All orders of four writes: only 0,1,2,3 validates (R1, R4)
    for (int s = 0; s < 256; s++) begin
      logic [1:0] o [4];
      for (int k = 0; k < 4; k++) o[k] = 2'(s >> (2 * (3 - k)));
      for (int k = 0; k < 4; k++) wr(o[k], 32'hC000_0000 + 32'(s * 16 + k), 1'b1);
      if (s == 8'h1B) begin
        chk("R1 ordered sweep", 128'(crc_value), 128'(ref_crc(mk[0], mk[1], mk[2], mk[3])));
      end else begin
        chk("R4 disordered sweep", 128'(crc_value), 128'h0);
      end
      chk("R10 sweep key", key_out, exp_key());
    end

    // Word-0 restart mid-run (R4)
    wr(2'd0, 32'h1111_1111, 1'b1); wr(2'd1, 32'h2222_2222, 1'b1);
    load_all(32'h3333_0000, 32'h4444_0000, 32'h5555_0000, 32'h6666_0000);
    chk("R4 restart crc", 128'(crc_value), 128'(ref_crc(32'h3333_0000, 32'h4444_0000, 32'h5555_0000, 32'h6666_0000)));
    // Repeated word aborts, then a later run recovers (R4)
    wr(2'd0, 32'h1, 1'b1); wr(2'd1, 32'h2, 1'b1); wr(2'd1, 32'h3, 1'b1);
    wr(2'd2, 32'h4, 1'b1); wr(2'd3, 32'h5, 1'b1);
    chk("R4 repeat aborts", 128'(crc_value), 128'h0);
    load_all(32'h10, 32'h20, 32'h30, 32'h40);
    chk("R4 fresh run", 128'(crc_value), 128'(ref_crc(32'h10, 32'h20, 32'h30, 32'h40)));
    // Single write after valid clears (R3)
    wr(2'd2, 32'h99, 1'b1);
    chk("R3 late write clears", 128'({crc_value, key_usable}), 128'h0);

    // Zero key gives zero CRC: not usable (R5)
    load_all(32'h0, 32'h0, 32'h0, 32'h0);
    chk("R5 zero crc bypass", 128'({crc_value, key_usable}), 128'h0);

    // Key lock (R6) with same-cycle write (R9)
    load_all(32'hDEAD_0001, 32'hBEEF_0002, 32'hCAFE_0003, 32'hF00D_0004);
    c = crc_value;
    key_lock_set = 1'b1; kw_wr = 1'b1; kw_idx = 2'd0; kw_data = 32'h7777_7777;
    @(negedge clk);
    key_lock_set = 1'b0; kw_wr = 1'b0;
    chk("R9 same-cycle key lock", key_out, exp_key());
    chk("R6 locked flag", 128'(key_locked), 128'h1);
    wr(2'd1, 32'h5555_5555, 1'b0);
    chk("R6 write ignored key", key_out, exp_key());
    chk("R6 write ignored crc", 128'(crc_value), 128'(c));
    repeat (3) @(negedge clk);
    chk("R6 sticky", 128'(key_locked), 128'h1);

    // Context lock (R7, R9)
    do_reset();
    cfg_wr = 1'b1;
    #1 chk("R7 cfg open", 128'(cfg_wr_ok), 128'h1);
    ctx_lock_set = 1'b1;
    #0.5 chk("R9 same-cycle cfg block", 128'(cfg_wr_ok), 128'h0);
    @(negedge clk);
    ctx_lock_set = 1'b0;
    #1 chk("R7 cfg blocked", 128'(cfg_wr_ok), 128'h0);
    chk("R7 locks", 128'({ctx_locked, key_locked}), 128'h3);
    cfg_wr = 1'b0;
    wr(2'd0, 32'h1234_5678, 1'b0);
    chk("R7 key frozen", key_out, 128'h0);

    // Global lock (R8, R9)
    do_reset();
    load_all(32'h0BAD_F00D, 32'h600D_CAFE, 32'h0102_0304, 32'hFFFF_0000);
    c = crc_value;
    glob_lock_set = 1'b1; kw_wr = 1'b1; kw_idx = 2'd3; kw_data = 32'h0;
    @(negedge clk);
    glob_lock_set = 1'b0; kw_wr = 1'b0;
    chk("R9 same-cycle global", key_out, exp_key());
    chk("R8 global flag", 128'(glob_locked), 128'h1);
    wr(2'd0, 32'hEEEE_EEEE, 1'b0);
    chk("R8 crc retained", 128'(crc_value), 128'(c));
    key_lock_set = 1'b1; ctx_lock_set = 1'b1; cfg_wr = 1'b1;
    #1 chk("R8 cfg blocked", 128'(cfg_wr_ok), 128'h0);
    @(negedge clk);
    key_lock_set = 1'b0; ctx_lock_set = 1'b0; cfg_wr = 1'b0;
    chk("R8 lock requests ignored", 128'({key_locked, ctx_locked}), 128'h0);
    chk("R8 key retained", key_out, exp_key());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule